// File: doc/BRIEF.md
# Four-Digit Multiplexed Display Scanner

This block drives a four-digit seven-segment display whose digits share one segment bus. Four 4-bit digit values come in: minute units, minute tens, hour units and hour tens. The block enables one digit at a time with a one-hot, active-high select. It holds each digit for a programmable number of clock cycles, then moves to the next. While a digit is enabled, that digit's segment pattern is on the shared bus. Hexadecimal letters are decoded as well as decimal digits.

The decimal point acts as the blinking separator between hours and minutes. It copies a slow blink input, but only while the hour-units digit is enabled, and stays dark at every other position. An active-low asynchronous reset clears the dwell counter and returns the scan to its first position.

The scan is a four-state machine with states `POS_MIN_U`, `POS_MIN_T`, `POS_HR_U` and `POS_HR_T`. Its transitions are:
- `POS_MIN_U`→`POS_MIN_T`
- `POS_MIN_T`→`POS_HR_U`
- `POS_HR_U`→`POS_HR_T`
- `POS_HR_T`→`POS_MIN_U`

Each transition is taken only on the cycle the dwell timer signals its last count. Reset enters `POS_MIN_U`.

Top module: `quad_digit_scanner`

## Requirements
- R1: While reset is low, the select is 0001, the dot is 0, and the bus shows the minute-units pattern.
- R2: Each position stays enabled for exactly DWELL_CYCLES clock cycles (default 12500) before the scan advances.
- R3: The scan order is minute units, minute tens, hour units, hour tens, and then it repeats from minute units.
- R4: The select is one-hot and active high: 0001 for minute units, 0010 for minute tens, 0100 for hour units and 1000 for hour tens.
- R5: Segments are active high, with bit 0 = a through bit 6 = g. Codes 0 to 9 give 0111111, 0000110, 1011011, 1001111, 1100110, 1101101, 1111101, 0000111, 1111111 and 1101111.
- R6: Codes 10 to 15 show A, b, C, d, E and F, as 1110111, 1111100, 0111001, 1011110, 1111001 and 1110001.
- R7: The bus carries the pattern of the digit whose select bit is high, and it changes on the same clock edge as the select.
- R8: When the select is 0100, the dot equals the blink input.
- R9: When the select is anything other than 0100, the dot is 0 whatever the blink input is.
- R10: A reset asserted in the middle of a scan returns the select to 0001 at once. After release, minute units again gets a full dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| min_units_i | input | 4 | Minute units digit code |
| min_tens_i | input | 4 | Minute tens digit code |
| hr_units_i | input | 4 | Hour units digit code |
| hr_tens_i | input | 4 | Hour tens digit code |
| blink_i | input | 1 | Slow blink input for the separator dot |
| sel_o | output | 4 | One-hot active-high digit enable |
| seg_o | output | 7 | Segment bus, bit 0 = a … bit 6 = g |
| dot_o | output | 1 | Decimal point for the enabled digit |

## Verification
A wrong scan state shows at the select port on the very next cycle. The select then sits at an out-of-order or non-one-hot code, and the bus shows the wrong digit's pattern along with it. A dwell counter that is off by one shows only as drift. The change of position then lands earlier or later than the expected edge, and the error grows by one cycle per position until the sampled window shows the next digit. Sampling a short dwell near both ends of every position over several frames makes that drift visible within one frame. A dot wired to the wrong position shows as a lit dot beside a minute or hour-tens digit during any frame in which the blink input is high.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

    localparam int NUM_POS = 4;
    localparam int CODE_W  = 4;
    localparam int SEG_W   = 7;

    typedef enum logic [1:0] {
        POS_MIN_U = 2'd0,
        POS_MIN_T = 2'd1,
        POS_HR_U  = 2'd2,
        POS_HR_T  = 2'd3
    } scan_pos_e;

endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int DWELL_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_o
);
    localparam int CNT_W = (DWELL_CYCLES > 2) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign step_o = (cnt_q == LAST);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (cnt_q == '0));

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import disp_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    output scan_pos_e           pos_o,
    output logic [NUM_POS-1:0]  sel_o
);
    scan_pos_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= POS_MIN_U;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (step_i) begin
            unique case (state_q)
                POS_MIN_U: state_d = POS_MIN_T;
                POS_MIN_T: state_d = POS_HR_U;
                POS_HR_U:  state_d = POS_HR_T;
                POS_HR_T:  state_d = POS_MIN_U;
                default:   state_d = POS_MIN_U;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            POS_MIN_U: sel_o = 4'b0001;
            POS_MIN_T: sel_o = 4'b0010;
            POS_HR_U:  sel_o = 4'b0100;
            POS_HR_T:  sel_o = 4'b1000;
            default:   sel_o = 4'b0001;
        endcase
    end

    assign pos_o = state_q;

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_o) == 1);

    // R3
    sel_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (sel_o == {$past(sel_o[NUM_POS-2:0]), $past(sel_o[NUM_POS-1])}));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(sel_o));

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import disp_scan_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_W-1:0]  seg_o
);
    // bit order {g,f,e,d,c,b,a}
    always_comb begin
        unique case (code_i)
            4'h0: seg_o = 7'b0111111;
            4'h1: seg_o = 7'b0000110;
            4'h2: seg_o = 7'b1011011;
            4'h3: seg_o = 7'b1001111;
            4'h4: seg_o = 7'b1100110;
            4'h5: seg_o = 7'b1101101;
            4'h6: seg_o = 7'b1111101;
            4'h7: seg_o = 7'b0000111;
            4'h8: seg_o = 7'b1111111;
            4'h9: seg_o = 7'b1101111;
            4'hA: seg_o = 7'b1110111;
            4'hB: seg_o = 7'b1111100;
            4'hC: seg_o = 7'b0111001;
            4'hD: seg_o = 7'b1011110;
            4'hE: seg_o = 7'b1111001;
            4'hF: seg_o = 7'b1110001;
            default: seg_o = '0;
        endcase
    end

endmodule

// File: rtl/quad_digit_scanner.sv
module quad_digit_scanner
    import disp_scan_pkg::*;
#(
    parameter int DWELL_CYCLES = 12500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  min_units_i,
    input  logic [3:0]  min_tens_i,
    input  logic [3:0]  hr_units_i,
    input  logic [3:0]  hr_tens_i,
    input  logic        blink_i,
    output logic [3:0]  sel_o,
    output logic [6:0]  seg_o,
    output logic        dot_o
);
    logic              step;
    scan_pos_e         pos;
    logic [CODE_W-1:0] code_sel;

    dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_o (step)
    );

    scan_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .pos_o  (pos),
        .sel_o  (sel_o)
    );

    always_comb begin
        unique case (pos)
            POS_MIN_U: code_sel = min_units_i;
            POS_MIN_T: code_sel = min_tens_i;
            POS_HR_U:  code_sel = hr_units_i;
            POS_HR_T:  code_sel = hr_tens_i;
            default:   code_sel = min_units_i;
        endcase
    end

    seg_decoder dec_i (
        .code_i (code_sel),
        .seg_o  (seg_o)
    );

    assign dot_o = (pos == POS_HR_U) && blink_i;

    // R9
    dot_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_o[2] |-> !dot_o);

    // R8
    dot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o[2] |-> (dot_o == blink_i));

endmodule

// File: tb/quad_digit_scanner_tb_top.sv
module quad_digit_scanner_tb_top;

    localparam int DW    = 8;
    localparam int FRAME = 4 * DW;

    typedef struct {
        logic [3:0] sel;
        logic [3:0] code;
        logic       dot;
        int         pos;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] d0 = '0, d1 = '0, d2 = '0, d3 = '0;
    logic       blink = 1'b0;
    logic [3:0] sel;
    logic [6:0] seg;
    logic       dot;

    int n_chk = 0;
    int n_bad = 0;
    int pcnt  = 0;
    bit mon_en = 1'b0;
    bit have = 1'b0;
    exp_item_t exp_q[$];
    exp_item_t cur;

    always #2 clk = ~clk;

    quad_digit_scanner #(.DWELL_CYCLES(DW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .min_units_i (d0),
        .min_tens_i  (d1),
        .hr_units_i  (d2),
        .hr_tens_i   (d3),
        .blink_i     (blink),
        .sel_o       (sel),
        .seg_o       (seg),
        .dot_o       (dot)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] c);
        case (c)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at t=%0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic compare(input exp_item_t it, input bit edge_sample);
        check(edge_sample ? "R2 select after step" : "R3 select order", {3'b0, sel}, {3'b0, it.sel});
        check("R4 one-hot", 7'($countones(sel)), 7'd1);
        if (edge_sample)
            check("R7 segments with select", seg, ref_seg(it.code));
        else if (it.code < 4'd10)
            check("R5 decimal pattern", seg, ref_seg(it.code));
        else
            check("R6 letter pattern", seg, ref_seg(it.code));
        check(it.pos == 2 ? "R8 dot follows blink" : "R9 dot dark", {6'b0, dot}, {6'b0, it.dot});
    endtask

    task automatic push_frame(input logic [3:0] a, input logic [3:0] b,
                              input logic [3:0] c, input logic [3:0] e, input logic bl);
        logic [3:0] codes [4];
        codes = '{a, b, c, e};
        d0 = a; d1 = b; d2 = c; d3 = e; blink = bl;
        for (int p = 0; p < 4; p++) begin
            exp_item_t it;
            it.sel  = 4'(1 << p);
            it.code = codes[p];
            it.dot  = (p == 2) ? bl : 1'b0;
            it.pos  = p;
            exp_q.push_back(it);
        end
    endtask

    task automatic wait_frame_end();
        do @(negedge clk); while ((pcnt % FRAME) != FRAME - 1);
    endtask

    always @(posedge clk) if (mon_en) pcnt <= pcnt + 1;

    // monitor: pops one expected item per position
    always @(negedge clk) begin
        if (mon_en) begin
            if ((pcnt % DW) == 1) begin
                if (exp_q.size() == 0) begin
                    have = 1'b0;
                end else begin
                    cur = exp_q.pop_front();
                    have = 1'b1;
                    compare(cur, 1'b1);
                end
            end else if (((pcnt % DW) == DW - 2) && have) begin
                compare(cur, 1'b0);
            end
        end
    end

    task automatic start_scan();
        @(negedge clk);
        #1;
        pcnt = 0;
        rst_n = 1'b1;
        mon_en = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        push_frame(4'd0, 4'd1, 4'd2, 4'd3, 1'b1);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset select", {3'b0, sel}, 7'b0000001);
        check("R1 reset dot", {6'b0, dot}, 7'd0);
        check("R1 reset segments", seg, ref_seg(4'd0));
        blink = 1'b0;
        exp_q[2].dot = 1'b0;

        start_scan();
        wait_frame_end(); push_frame(4'd4, 4'd5, 4'd6, 4'd7, 1'b1);
        wait_frame_end(); push_frame(4'd8, 4'd9, 4'hA, 4'hB, 1'b1);
        wait_frame_end(); push_frame(4'hC, 4'hD, 4'hE, 4'hF, 1'b0);
        wait_frame_end(); push_frame(4'hF, 4'd0, 4'd8, 4'hA, 1'b1);
        wait_frame_end();
        mon_en = 1'b0;
        have = 1'b0;
        exp_q.delete();

        // R10 reset in the middle of the hour-units dwell
        push_frame(4'd3, 4'd9, 4'd1, 4'd2, 1'b1);
        start_scan();
        do @(negedge clk); while (pcnt != 2 * DW + 3);
        #1;
        mon_en = 1'b0;
        have = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R10 select after mid-scan reset", {3'b0, sel}, 7'b0000001);
        check("R10 dot after mid-scan reset", {6'b0, dot}, 7'd0);
        exp_q.delete();
        push_frame(4'd3, 4'd9, 4'd1, 4'd2, 1'b1);
        repeat (2) @(negedge clk);
        start_scan();
        wait_frame_end();
        mon_en = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule